// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between up to 64 interrupt sources and a processor core. Each source's request is the OR of a level input and a software force bit. That request is then gated by a per-source enable bit. A per-source type bit sends each gated request to one of two core request lines: normal or fast.

Normal requests carry a programmable priority per source. A global mask threshold blocks every normal request whose level is at or below it. Among the normal requests that pass, the block picks a single winner and reports its source number and level. On the fast side, the block reports the highest-numbered pending source.

Software reaches all state through a word-addressed register bus. Writes are single-cycle. Reads are combinational. An enable bit can be set or cleared on its own by writing a source number, so software never needs a read-modify-write. The winner and both request lines follow the inputs in the same cycle, with no pipeline stage.

Top module: `pvic_top`

## Requirements
- R1: After reset, all enable, type, force and priority bits read 0, the mask register reads 32'hFFFFFFFF (no masking), both request outputs are low, the normal vector reads 32'h0000FFFF and the fast vector reads 32'hFFFFFFFF.
- R2: A write of value n < 64 to word 0 sets enable bit n from the next cycle on, and changes no other enable bit. The enable words are at address 8 (sources 31..0) and address 9 (sources 63..32); bit i of a word is source 32*word+i.
- R3: A write of value n < 64 to word 1 clears enable bit n from the next cycle on, and changes no other enable bit.
- R4: A write of a value of 64 or more to word 0 or word 1 leaves every enable bit unchanged.
- R5: A source is pending when its input or its force bit is high and its enable bit is set. If its type bit is 1 (type words at 10 and 11), it is pending as fast and appears in fast-pending words 20 and 21. Otherwise it is pending as normal and appears in normal-pending words 18 and 19.
- R6: A force bit (force words at 12 and 13) makes its source pending exactly as an asserted input would.
- R7: Raw-status words 16 and 17 show the request inputs before force and enable gating.
- R8: Each source has a 4-bit priority. Priority words 32 to 39 each hold eight sources; source s is at word 32+s/8, bits 4*(s%8)+3 to 4*(s%8). The normal vector (word 3) reports the winning level in bits 19:16 and the winning source number in bits 15:0, and the higher level wins.
- R9: When pending normal sources share the top level, the one with the higher source number wins.
- R10: The mask register (word 2, 5-bit signed, read sign-extended) blocks normal sources whose level is at or below its value. The normal request output is high exactly when an unblocked pending normal source exists.
- R11: The fast vector (word 4) reports the highest-numbered fast-pending source, and the fast request output is high exactly when any fast-pending source exists.
- R12: With no eligible source, the normal vector reads 32'h0000FFFF and the fast vector reads 32'hFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 64 | Level request per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| norm_irq | output | 1 | Normal request to the core |
| fast_irq | output | 1 | Fast request to the core |

## Verification
The bench builds the block with its default parameters: 64 sources and 4-bit priorities. These values place sources in both the low and the high word, so the split of the enable, type, force and pending words is exercised on both sides of bit 32. The top source number, 63, and the all-ones priority field of 15 are also within reach. With the 5-bit signed mask, the bench can reach both the "no masking" value and a mask that blocks every level at or below a given priority.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int unsigned REG_AW = 6;
  localparam logic [REG_AW-1:0] A_ENSET = 6'd0;
  localparam logic [REG_AW-1:0] A_ENCLR = 6'd1;
  localparam logic [REG_AW-1:0] A_MASK  = 6'd2;
  localparam logic [REG_AW-1:0] A_NVEC  = 6'd3;
  localparam logic [REG_AW-1:0] A_FVEC  = 6'd4;
  localparam logic [REG_AW-1:0] A_EN0   = 6'd8;
  localparam logic [REG_AW-1:0] A_TYPE0 = 6'd10;
  localparam logic [REG_AW-1:0] A_FRC0  = 6'd12;
  localparam logic [REG_AW-1:0] A_RAW0  = 6'd16;
  localparam logic [REG_AW-1:0] A_NPND0 = 6'd18;
  localparam logic [REG_AW-1:0] A_FPND0 = 6'd20;
  localparam logic [REG_AW-1:0] A_PRIO0 = 6'd32;
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs
  import pvic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [REG_AW-1:0]           reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [NUM_SRC-1:0]          en_q,
  output logic [NUM_SRC-1:0]          type_q,
  output logic [NUM_SRC-1:0]          frc_q,
  output logic [NUM_SRC*PRIO_W-1:0]   prio_q,
  output logic signed [PRIO_W:0]      mask_q
);
  localparam int unsigned SRC_W = $clog2(NUM_SRC);
  localparam int unsigned NW    = NUM_SRC / 32;
  localparam int unsigned NPR   = NUM_SRC * PRIO_W / 32;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      type_q <= '0;
      frc_q  <= '0;
      prio_q <= '0;
      mask_q <= '1;
    end else if (reg_wr) begin
      if (reg_addr == A_ENSET && reg_wdata < NUM_SRC)
        en_q[reg_wdata[SRC_W-1:0]] <= 1'b1;
      if (reg_addr == A_ENCLR && reg_wdata < NUM_SRC)
        en_q[reg_wdata[SRC_W-1:0]] <= 1'b0;
      if (reg_addr == A_MASK)
        mask_q <= reg_wdata[PRIO_W:0];
      for (int w = 0; w < NW; w++) begin
        if (reg_addr == REG_AW'(A_EN0 + w))   en_q[32*w +: 32]   <= reg_wdata;
        if (reg_addr == REG_AW'(A_TYPE0 + w)) type_q[32*w +: 32] <= reg_wdata;
        if (reg_addr == REG_AW'(A_FRC0 + w))  frc_q[32*w +: 32]  <= reg_wdata;
      end
      for (int k = 0; k < NPR; k++) begin
        if (reg_addr == REG_AW'(A_PRIO0 + k)) prio_q[32*k +: 32] <= reg_wdata;
      end
    end
  end
endmodule

// File: rtl/pvic_norm_arb.sv
module pvic_norm_arb #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        npnd,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic signed [PRIO_W:0]    mask,
  output logic                      hit,
  output logic [SRC_W-1:0]          win_num,
  output logic [PRIO_W-1:0]         win_prio
);
  always_comb begin
    hit      = 1'b0;
    win_num  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (npnd[i] && ($signed({1'b0, prio[i*PRIO_W +: PRIO_W]}) > mask)) begin
        // ascending scan with >= hands ties to the higher source number
        if (!hit || prio[i*PRIO_W +: PRIO_W] >= win_prio) begin
          hit      = 1'b1;
          win_num  = SRC_W'(i);
          win_prio = prio[i*PRIO_W +: PRIO_W];
        end
      end
    end
  end
endmodule

// File: rtl/pvic_fast_pick.sv
module pvic_fast_pick #(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] fpnd,
  output logic               hit,
  output logic [SRC_W-1:0]   num
);
  always_comb begin
    hit = 1'b0;
    num = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (fpnd[i]) begin
        hit = 1'b1;
        num = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               norm_irq,
  output logic               fast_irq
);
  localparam int unsigned SRC_W = $clog2(NUM_SRC);
  localparam int unsigned NW    = NUM_SRC / 32;
  localparam int unsigned NPR   = NUM_SRC * PRIO_W / 32;

  logic [NUM_SRC-1:0]        en, typ, frc, act, npnd, fpnd;
  logic [NUM_SRC*PRIO_W-1:0] prio;
  logic signed [PRIO_W:0]    mask;
  logic                      n_hit, f_hit;
  logic [SRC_W-1:0]          n_num, f_num;
  logic [PRIO_W-1:0]         n_prio;
  logic [31:0]               nvec, fvec;

  pvic_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .en_q(en), .type_q(typ), .frc_q(frc),
    .prio_q(prio), .mask_q(mask)
  );

  assign act  = (irq_src | frc) & en;
  assign npnd = act & ~typ;
  assign fpnd = act & typ;

  pvic_norm_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_narb (
    .npnd(npnd), .prio(prio), .mask(mask),
    .hit(n_hit), .win_num(n_num), .win_prio(n_prio)
  );

  pvic_fast_pick #(.NUM_SRC(NUM_SRC)) u_fpick (
    .fpnd(fpnd), .hit(f_hit), .num(f_num)
  );

  assign norm_irq = n_hit;
  assign fast_irq = f_hit;
  assign nvec = n_hit ? {{(16-PRIO_W){1'b0}}, n_prio, 16'(n_num)} : 32'h0000_FFFF;
  assign fvec = f_hit ? 32'(f_num) : 32'hFFFF_FFFF;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_MASK)      reg_rdata = {{(31-PRIO_W){mask[PRIO_W]}}, mask};
    else if (reg_addr == A_NVEC) reg_rdata = nvec;
    else if (reg_addr == A_FVEC) reg_rdata = fvec;
    for (int w = 0; w < NW; w++) begin
      if (reg_addr == REG_AW'(A_EN0 + w))   reg_rdata = en[32*w +: 32];
      if (reg_addr == REG_AW'(A_TYPE0 + w)) reg_rdata = typ[32*w +: 32];
      if (reg_addr == REG_AW'(A_FRC0 + w))  reg_rdata = frc[32*w +: 32];
      if (reg_addr == REG_AW'(A_RAW0 + w))  reg_rdata = irq_src[32*w +: 32];
      if (reg_addr == REG_AW'(A_NPND0 + w)) reg_rdata = npnd[32*w +: 32];
      if (reg_addr == REG_AW'(A_FPND0 + w)) reg_rdata = fpnd[32*w +: 32];
    end
    for (int k = 0; k < NPR; k++) begin
      if (reg_addr == REG_AW'(A_PRIO0 + k)) reg_rdata = prio[32*k +: 32];
    end
  end
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk
  import pvic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        reg_wr,
  input logic [REG_AW-1:0]           reg_addr,
  input logic [31:0]                 reg_wdata,
  input logic                        norm_irq,
  input logic                        fast_irq,
  input logic [NUM_SRC-1:0]          en,
  input logic [NUM_SRC-1:0]          npnd,
  input logic [NUM_SRC-1:0]          fpnd,
  input logic [NUM_SRC*PRIO_W-1:0]   prio,
  input logic signed [PRIO_W:0]      mask,
  input logic [SRC_W-1:0]            n_num,
  input logic [SRC_W-1:0]            f_num
);
  // R2
  enset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ENSET && reg_wdata < NUM_SRC) |=> en[$past(reg_wdata[SRC_W-1:0])]);
  // R3
  enclr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ENCLR && reg_wdata < NUM_SRC) |=> !en[$past(reg_wdata[SRC_W-1:0])]);
  // R4
  oor_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == A_ENSET || reg_addr == A_ENCLR) && reg_wdata >= NUM_SRC) |=> $stable(en));
  // R5
  type_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (npnd & fpnd) == '0);
  // R8
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_irq |-> npnd[n_num]);
  // R10
  winner_above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_irq |-> ($signed({1'b0, prio[n_num*PRIO_W +: PRIO_W]}) > mask));
  // R11
  fast_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_irq |-> ((fpnd >> f_num) == NUM_SRC'(1)));
  // R12
  fast_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fpnd == '0) |-> !fast_irq);
endmodule

bind pvic_top pvic_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/pvic_top_test.sv
module pvic_top_test;
  localparam int PERIOD = 10;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_src = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        norm_irq, fast_irq;
  int total = 0;
  int bad = 0;

  pvic_top uut (.*);

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD*100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    irq_src = '0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(8, d);  chk("R1 en lo", d, 0);
    rd(9, d);  chk("R1 en hi", d, 0);
    rd(11, d); chk("R1 type hi", d, 0);
    rd(12, d); chk("R1 force lo", d, 0);
    rd(39, d); chk("R1 prio", d, 0);
    rd(2, d);  chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(3, d);  chk("R1 nvec", d, 32'h0000_FFFF);
    rd(4, d);  chk("R1 fvec", d, 32'hFFFF_FFFF);
    chk("R1 irq outs", {30'd0, norm_irq, fast_irq}, 0);
  endtask

  task automatic t_by_number();
    logic [31:0] d;
    do_reset();
    wr(0, 40); wr(0, 3); wr(0, 63);
    rd(8, d); chk("R2 set lo", d, 32'h0000_0008);
    rd(9, d); chk("R2 set hi", d, 32'h8000_0100);
    wr(1, 3);
    rd(8, d); chk("R3 clear lo", d, 0);
    rd(9, d); chk("R3 other bits kept", d, 32'h8000_0100);
    wr(0, 64); wr(0, 32'h8000_0005); wr(1, 100); wr(1, 32'h0001_0028);
    rd(8, d); chk("R4 oor lo", d, 0);
    rd(9, d); chk("R4 oor hi", d, 32'h8000_0100);
  endtask

  task automatic t_raw_type();
    logic [31:0] d;
    do_reset();
    irq_src = 64'h0000_0100_0000_0020;
    rd(16, d); chk("R7 raw lo ungated", d, 32'h0000_0020);
    rd(17, d); chk("R7 raw hi ungated", d, 32'h0000_0100);
    rd(18, d); chk("R5 nothing enabled", d, 0);
    wr(0, 5); wr(0, 40); wr(11, 32'h0000_0100);
    rd(18, d); chk("R5 normal pend", d, 32'h0000_0020);
    rd(21, d); chk("R5 fast pend", d, 32'h0000_0100);
    rd(19, d); chk("R5 fast not normal", d, 0);
    rd(4, d);  chk("R11 fvec", d, 40);
    chk("R11 fast_irq", {31'd0, fast_irq}, 1);
    chk("R10 norm_irq", {31'd0, norm_irq}, 1);
    irq_src[50] = 1'b1; wr(0, 50); wr(11, 32'h0004_0100);
    rd(4, d);  chk("R11 highest fast", d, 50);
    irq_src = '0;
    rd(4, d);  chk("R12 fvec none", d, 32'hFFFF_FFFF);
    chk("R11 fast low", {31'd0, fast_irq}, 0);
  endtask

  task automatic t_force();
    logic [31:0] d;
    do_reset();
    wr(0, 12); wr(12, 32'h0000_1000);
    rd(18, d); chk("R6 force pend", d, 32'h0000_1000);
    rd(3, d);  chk("R6 force vec", d, 32'h0000_000C);
    chk("R6 norm_irq", {31'd0, norm_irq}, 1);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    do_reset();
    wr(8, 32'hFFFF_FFFF); wr(9, 32'hFFFF_FFFF);
    wr(33, 32'h0000_0300);   // source 10 level 3
    wr(34, 32'h0007_0000);   // source 20 level 7
    wr(39, 32'h0005_0000);   // source 60 level 5
    wr(12, 32'h0010_0400); wr(13, 32'h1000_0000);
    rd(3, d); chk("R8 top level", d, 32'h0007_0014);
    wr(39, 32'h0007_0000);
    rd(3, d); chk("R9 tie to higher num", d, 32'h0007_003C);
    wr(2, 7);
    rd(3, d); chk("R12 all masked nvec", d, 32'h0000_FFFF);
    chk("R10 masked norm_irq", {31'd0, norm_irq}, 0);
    wr(2, 6);
    rd(3, d); chk("R10 above mask", d, 32'h0007_003C);
    wr(12, 32'h0000_0400); wr(13, 0);
    wr(2, 3);
    rd(3, d); chk("R10 equal level blocked", d, 32'h0000_FFFF);
    wr(2, 2);
    rd(2, d); chk("R10 mask readback", d, 2);
    rd(3, d); chk("R10 just above", d, 32'h0003_000A);
  endtask

  initial begin
    t_reset();
    t_by_number();
    t_raw_type();
    t_force();
    t_priority();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule